// File: doc/BRIEF.md
# Interrupt-Paced Word DMA Engine

This block moves a block of words between one device data register and a buffer in memory without the processor touching each word. Software programs a device base address, the data register's offset from that base, a buffer pointer and a word count. It then writes the control register with the go bit set. Every word makes two trips over a request/ready master port: a read from the source, then a write of the same value to the destination.

In paced mode the engine waits for one rising edge of the device interrupt line before each word, so the device sets the rate. In block mode the words follow each other with no gap. When the last word has been written, the engine returns to idle and raises a completion interrupt. That interrupt stays high until software acknowledges it. The engine services no device interrupt until the device base address has been written at least once since reset.

Top module: `wdma_engine`

## Requirements
- R1: While reset is held and after it is released, `m_req` and `done_irq` are low until software starts a transfer.
- R2: Writing 1 to bit 0 of the control register (select 4) starts one transfer only if the engine is idle. The go bit clears itself when the engine accepts it. A control write made while a transfer is running changes neither the start, the direction nor the mode.
- R3: Each word is a read request (`m_we`=0) followed by a write request (`m_we`=1) that carries the value read. A request holds its type and data until `m_ready` is seen high.
- R4: The device address is the device base (select 0) plus the register offset (select 1). The buffer address for word j is the buffer pointer (select 2) plus j, with j counting from 0.
- R5: Control bit 1 selects the direction. 0 reads the device and writes the buffer. 1 reads the buffer and writes the device.
- R6: With control bit 2 set (paced mode), the engine issues no request until a rising edge of `dev_irq`. Each edge moves exactly one word, and a line held high moves only one word.
- R7: Rising edges of `dev_irq` that occur before the device base register has been written since reset are dropped.
- R8: A transfer moves exactly the number of words in the count register (select 3) and then issues no further request. A count of zero completes at once with no master access.
- R9: `done_irq` rises in the cycle after the final write handshake, or after a zero-count start is accepted. It stays high until a control write with bit 3 set.
- R10: In block mode (control bit 2 clear), `m_req` stays high from the first read to the last write with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 base, 1 offset, 2 pointer, 3 count, 4 control |
| cfg_wdata | input | DW | Register write data |
| dev_irq | input | 1 | Device event line, one word per rising edge in paced mode |
| m_req | output | 1 | Master request |
| m_we | output | 1 | Master request is a write |
| m_addr | output | AW | Master word address |
| m_wdata | output | DW | Master write data |
| m_ready | input | 1 | Master handshake complete this cycle |
| m_rdata | input | DW | Master read data, valid with `m_ready` on a read |
| done_irq | output | 1 | Completion interrupt to the processor |

## Verification
The assertions assume that the master side raises `m_ready` only while `m_req` is high, and that it returns read data in the same cycle as that `m_ready`. The bench's responder meets both conditions. It waits a fixed latency after a request appears, then drops `m_ready` for one cycle after every handshake. The assertions also assume software writes the count and the control register only while the engine is idle. The one exception is a deliberate control write during a running transfer. The bench changes the offset, pointer and count only between transfers, and it pulses `dev_irq` on falling edges well away from any word that is still in flight.

// File: rtl/wdma_pkg.sv
`timescale 1ns/1ps
package wdma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_RD   = 2'd2,
      ST_WR   = 2'd3
   } wdma_state_e;

   localparam logic [2:0] SEL_DEV_BASE = 3'd0;
   localparam logic [2:0] SEL_DEV_OFF  = 3'd1;
   localparam logic [2:0] SEL_BUF_PTR  = 3'd2;
   localparam logic [2:0] SEL_WORDS    = 3'd3;
   localparam logic [2:0] SEL_CTRL     = 3'd4;

   localparam int unsigned CB_GO    = 0;
   localparam int unsigned CB_TODEV = 1;
   localparam int unsigned CB_PACED = 2;
   localparam int unsigned CB_ACK   = 3;

   typedef struct packed {
      logic to_dev;
      logic paced;
   } wdma_mode_t;

endpackage

// File: rtl/wdma_regs.sv
`timescale 1ns/1ps
module wdma_regs
   import wdma_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32,
   parameter int unsigned CW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [2:0]      cfg_sel,
   input  logic [DW-1:0]   cfg_wdata,
   input  logic            engine_idle,
   input  logic            start_ack,
   input  logic            done_set,
   output logic [AW-1:0]   dev_base,
   output logic [AW-1:0]   dev_off,
   output logic [AW-1:0]   buf_ptr,
   output logic [CW-1:0]   word_total,
   output wdma_mode_t      mode,
   output logic            go_pend,
   output logic            base_valid,
   output logic            done_irq
);

   logic wr_ctrl;
   logic cfg_unused;

   assign wr_ctrl    = cfg_we && (cfg_sel == SEL_CTRL);
   assign cfg_unused = ^cfg_wdata;

   generate
      if (DW < AW || DW < CW || DW < 4) begin : g_bad_width
         $error("wdma_regs: data width too narrow for the registers");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_base   <= '0;
         dev_off    <= '0;
         buf_ptr    <= '0;
         word_total <= '0;
         base_valid <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_DEV_BASE: begin
               dev_base   <= cfg_wdata[AW-1:0];
               base_valid <= 1'b1;
            end
            SEL_DEV_OFF: dev_off    <= cfg_wdata[AW-1:0];
            SEL_BUF_PTR: buf_ptr    <= cfg_wdata[AW-1:0];
            SEL_WORDS:   word_total <= cfg_wdata[CW-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= '0;
         go_pend <= 1'b0;
      end else begin
         if (wr_ctrl && engine_idle) begin
            mode.to_dev <= cfg_wdata[CB_TODEV];
            mode.paced  <= cfg_wdata[CB_PACED];
         end
         if (start_ack)
            go_pend <= 1'b0;
         else if (wr_ctrl && engine_idle && cfg_wdata[CB_GO])
            go_pend <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         done_irq <= 1'b0;
      else if (done_set)
         done_irq <= 1'b1;
      else if (wr_ctrl && cfg_wdata[CB_ACK])
         done_irq <= 1'b0;
   end

   // R9: completion stays up until acknowledged
   p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_irq && !(wr_ctrl && cfg_wdata[CB_ACK])) |=> done_irq);

   // R7: base written flag never falls without reset
   p_base_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      base_valid |=> base_valid);

endmodule

// File: rtl/wdma_agen.sv
`timescale 1ns/1ps
module wdma_agen #(
   parameter int unsigned AW       = 32,
   parameter int unsigned CW       = 16,
   parameter int unsigned STEP_LG2 = 0
) (
   input  logic [AW-1:0] dev_base,
   input  logic [AW-1:0] dev_off,
   input  logic [AW-1:0] buf_ptr,
   input  logic [CW-1:0] idx,
   input  logic          to_dev,
   input  logic          wr_phase,
   output logic [AW-1:0] m_addr
);

   logic [AW-1:0] dev_addr;
   logic [AW-1:0] buf_off;
   logic [AW-1:0] buf_addr;
   logic          use_dev;

   generate
      if (CW > AW) begin : g_bad_idx
         $error("wdma_agen: index wider than address");
      end
      if (STEP_LG2 == 0) begin : g_unit_step
         assign buf_off = AW'(idx);
      end else begin : g_scaled_step
         assign buf_off = AW'(idx) << STEP_LG2;
      end
   endgenerate

   assign dev_addr = dev_base + dev_off;
   assign buf_addr = buf_ptr + buf_off;
   // read side uses the device when moving toward the buffer, and vice versa
   assign use_dev  = (to_dev == wr_phase);
   assign m_addr   = use_dev ? dev_addr : buf_addr;

endmodule

// File: rtl/wdma_seq.sv
`timescale 1ns/1ps
module wdma_seq
   import wdma_pkg::*;
#(
   parameter int unsigned DW        = 32,
   parameter int unsigned CW        = 16,
   parameter bit          EDGE_PACE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_pend,
   input  logic [CW-1:0] word_total,
   input  logic          paced,
   input  logic          base_valid,
   input  logic          dev_irq,
   input  logic          m_ready,
   input  logic [DW-1:0] m_rdata,
   output logic          start_ack,
   output logic          done_set,
   output wdma_state_e   state,
   output logic [CW-1:0] idx,
   output logic          wr_phase,
   output logic          m_req,
   output logic          m_we,
   output logic [DW-1:0] m_wdata
);

   wdma_state_e   state_q, state_d;
   logic [CW-1:0] remain_q;
   logic [CW-1:0] idx_q;
   logic [DW-1:0] data_q;
   logic          fire;
   logic          consume;
   logic          last_word;

   assign consume   = (state_q == ST_ARM) && fire;
   assign last_word = (remain_q == CW'(1));

   generate
      if (EDGE_PACE) begin : g_edge
         logic irq_q;
         logic evt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
               evt_q <= 1'b0;
            end else begin
               irq_q <= dev_irq;
               evt_q <= (evt_q & ~(consume | start_ack)) |
                        (dev_irq & ~irq_q & base_valid);
            end
         end
         assign fire = evt_q;
      end else begin : g_level
         assign fire = dev_irq & base_valid;
      end
   endgenerate

   always_comb begin
      state_d   = state_q;
      start_ack = 1'b0;
      done_set  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (go_pend) begin
               start_ack = 1'b1;
               if (word_total == '0)
                  done_set = 1'b1;
               else
                  state_d = paced ? ST_ARM : ST_RD;
            end
         end
         ST_ARM: begin
            if (fire)
               state_d = ST_RD;
         end
         ST_RD: begin
            if (m_ready)
               state_d = ST_WR;
         end
         ST_WR: begin
            if (m_ready) begin
               if (last_word) begin
                  done_set = 1'b1;
                  state_d  = ST_IDLE;
               end else begin
                  state_d = paced ? ST_ARM : ST_RD;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         remain_q <= '0;
         idx_q    <= '0;
         data_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && go_pend) begin
            remain_q <= word_total;
            idx_q    <= '0;
         end
         if (state_q == ST_RD && m_ready)
            data_q <= m_rdata;
         if (state_q == ST_WR && m_ready) begin
            remain_q <= remain_q - CW'(1);
            idx_q    <= idx_q + CW'(1);
         end
      end
   end

   assign state    = state_q;
   assign idx      = idx_q;
   assign wr_phase = (state_q == ST_WR);
   assign m_req    = (state_q == ST_RD) || (state_q == ST_WR);
   assign m_we     = (state_q == ST_WR);
   assign m_wdata  = data_q;

   // R3: a stalled request keeps its kind and its data
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ready) |=> (m_req && $stable(m_we) && $stable(m_wdata)));

   // R3: a completed read is followed by the write
   p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_we && m_ready) |=> (m_req && m_we));

   // R8: each write handshake uses up one word
   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && m_we && m_ready) |=> (remain_q == $past(remain_q) - CW'(1)));

   // R7: no read leaves the wait state before the base is known
   p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARM && !base_valid) |=> (state_q != ST_RD));

   // R10: block mode chains the next read straight after a write
   p_block_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && m_we && m_ready && !last_word && !paced) |=> (m_req && !m_we));

endmodule

// File: rtl/wdma_engine.sv
`timescale 1ns/1ps
module wdma_engine
   import wdma_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned DW        = 32,
   parameter int unsigned CW        = 16,
   parameter bit          EDGE_PACE = 1'b1,
   parameter int unsigned STEP_LG2  = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_sel,
   input  logic [DW-1:0] cfg_wdata,
   input  logic          dev_irq,
   output logic          m_req,
   output logic          m_we,
   output logic [AW-1:0] m_addr,
   output logic [DW-1:0] m_wdata,
   input  logic          m_ready,
   input  logic [DW-1:0] m_rdata,
   output logic          done_irq
);

   localparam int unsigned MAX_WORDS = (1 << CW) - 1;

   generate
      if (CW < 1 || CW > AW || MAX_WORDS < 1) begin : g_bad_count
         $error("wdma_engine: count width out of range");
      end
      if (STEP_LG2 >= AW) begin : g_bad_step
         $error("wdma_engine: step shift exceeds address width");
      end
   endgenerate

   logic [AW-1:0] dev_base;
   logic [AW-1:0] dev_off;
   logic [AW-1:0] buf_ptr;
   logic [CW-1:0] word_total;
   wdma_mode_t    mode;
   logic          go_pend;
   logic          base_valid;
   logic          start_ack;
   logic          done_set;
   wdma_state_e   state;
   logic [CW-1:0] idx;
   logic          wr_phase;
   logic          engine_idle;

   assign engine_idle = (state == ST_IDLE);

   wdma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .engine_idle(engine_idle),
      .start_ack  (start_ack),
      .done_set   (done_set),
      .dev_base   (dev_base),
      .dev_off    (dev_off),
      .buf_ptr    (buf_ptr),
      .word_total (word_total),
      .mode       (mode),
      .go_pend    (go_pend),
      .base_valid (base_valid),
      .done_irq   (done_irq)
   );

   wdma_seq #(.DW(DW), .CW(CW), .EDGE_PACE(EDGE_PACE)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_pend    (go_pend),
      .word_total (word_total),
      .paced      (mode.paced),
      .base_valid (base_valid),
      .dev_irq    (dev_irq),
      .m_ready    (m_ready),
      .m_rdata    (m_rdata),
      .start_ack  (start_ack),
      .done_set   (done_set),
      .state      (state),
      .idx        (idx),
      .wr_phase   (wr_phase),
      .m_req      (m_req),
      .m_we       (m_we),
      .m_wdata    (m_wdata)
   );

   wdma_agen #(.AW(AW), .CW(CW), .STEP_LG2(STEP_LG2)) u_agen (
      .dev_base (dev_base),
      .dev_off  (dev_off),
      .buf_ptr  (buf_ptr),
      .idx      (idx),
      .to_dev   (mode.to_dev),
      .wr_phase (wr_phase),
      .m_addr   (m_addr)
   );

   // R9: the sequencer's completion reaches the interrupt line one cycle later
   p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |=> done_irq);

   // R1: an idle engine drives no request
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (engine_idle && !go_pend) |=> !m_req);

endmodule

// File: tb/wdma_engine_tb.sv
`timescale 1ns/1ps
module wdma_engine_tb;
   import wdma_pkg::*;

   localparam int AW  = 32;
   localparam int DW  = 32;
   localparam int CW  = 16;
   localparam int LAT = 1;
   localparam logic [31:0] BASE = 32'h100;
   localparam int NV = 5;
   // {to_dev, paced, count[7:0], offset[7:0], pointer[15:0]}
   localparam logic [33:0] VECS [NV] = '{
      {1'b0, 1'b0, 8'd4, 8'h10, 16'h0000},
      {1'b1, 1'b0, 8'd3, 8'h08, 16'h0020},
      {1'b1, 1'b1, 8'd2, 8'h0C, 16'h0030},
      {1'b0, 1'b0, 8'd1, 8'h00, 16'h0050},
      {1'b1, 1'b0, 8'd5, 8'h3C, 16'h00C0}
   };

   logic          clk;
   logic          rst_n;
   logic          cfg_we;
   logic [2:0]    cfg_sel;
   logic [DW-1:0] cfg_wdata;
   logic          dev_irq;
   logic          m_req;
   logic          m_we;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_wdata;
   logic          m_ready;
   logic [DW-1:0] m_rdata;
   logic          done_irq;

   wdma_engine #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .dev_irq(dev_irq), .m_req(m_req), .m_we(m_we),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready),
      .m_rdata(m_rdata), .done_irq(done_irq)
   );

   int errors = 0;
   int checks = 0;
   int wr_cnt = 0;
   int req_cycles = 0;
   int gap = 0;
   int exp_words = 0;
   int w0 = 0;
   bit track = 0;
   bit seen = 0;
   logic [31:0] dev_seq = 0;
   logic [31:0] wlog_a [256];
   logic [31:0] wlog_d [256];

   initial begin
      clk = 1'b0;
      forever #2.5 clk = ~clk;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // master-side responder: fixed latency, one quiet cycle after each handshake
   initial begin
      int cnt;
      cnt = 0;
      m_ready = 1'b0;
      m_rdata = '0;
      forever begin
         @(negedge clk);
         if (m_req) req_cycles++;
         if (track) begin
            if (seen && !m_req) gap++;
            if (m_req) seen = 1'b1;
         end
         if (m_ready) begin
            m_ready = 1'b0;
            cnt = 0;
         end else if (m_req) begin
            if (cnt >= LAT) begin
               m_ready = 1'b1;
               if (m_we) begin
                  wlog_a[wr_cnt % 256] = m_addr;
                  wlog_d[wr_cnt % 256] = m_wdata;
                  wr_cnt++;
                  if (track && (wr_cnt - w0) == exp_words) track = 1'b0;
               end else if (m_addr >= BASE) begin
                  m_rdata = 32'h5A00_0000 | dev_seq;
                  dev_seq++;
               end else begin
                  m_rdata = 32'hC0DE_0000 ^ m_addr;
               end
            end else begin
               cnt++;
            end
         end
      end
   end

   task automatic cfg_wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_sel = s;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_irq();
      @(negedge clk);
      dev_irq = 1'b1;
      repeat (2) @(negedge clk);
      dev_irq = 1'b0;
   endtask

   task automatic run_vec(input logic [33:0] v);
      logic        to_dev, paced;
      logic [7:0]  n, off;
      logic [15:0] ptr;
      logic [31:0] ds0, ea, ed;
      {to_dev, paced, n, off, ptr} = v;
      cfg_wr(SEL_DEV_OFF, {24'd0, off});
      cfg_wr(SEL_BUF_PTR, {16'd0, ptr});
      cfg_wr(SEL_WORDS, {24'd0, n});
      w0 = wr_cnt;
      ds0 = dev_seq;
      exp_words = n;
      gap = 0;
      seen = 1'b0;
      track = 1'b1;
      cfg_wr(SEL_CTRL, 32'h9 | ({31'd0, to_dev} << 1) | ({31'd0, paced} << 2));
      if (paced) begin
         for (int i = 0; i < n; i++) begin
            pulse_irq();
            repeat (12) @(negedge clk);
         end
      end else begin
         repeat (n * 8 + 6) @(negedge clk);
      end
      chk("R8 words moved", wr_cnt - w0, {24'd0, n});
      for (int j = 0; j < n; j++) begin
         if (to_dev) begin
            ea = BASE + off;
            ed = 32'hC0DE_0000 ^ (32'(ptr) + j);
         end else begin
            ea = 32'(ptr) + j;
            ed = 32'h5A00_0000 | (ds0 + j);
         end
         chk("R4 write address", wlog_a[(w0 + j) % 256], ea);
         chk("R5 R3 write data", wlog_d[(w0 + j) % 256], ed);
      end
      chk("R9 done raised", {31'd0, done_irq}, 32'd1);
      if (!paced) chk("R10 no idle gap", gap, 0);
      track = 1'b0;
   endtask

   initial begin
      int r0;
      rst_n = 1'b0;
      cfg_we = 1'b0;
      cfg_sel = '0;
      cfg_wdata = '0;
      dev_irq = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 req in reset", {31'd0, m_req}, 0);
      chk("R1 done in reset", {31'd0, done_irq}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 req after reset", {31'd0, m_req}, 0);
      chk("R1 done after reset", {31'd0, done_irq}, 0);

      // paced transfer armed before the base is written
      cfg_wr(SEL_DEV_OFF, 32'h8);
      cfg_wr(SEL_BUF_PTR, 32'h40);
      cfg_wr(SEL_WORDS, 32'd2);
      r0 = req_cycles;
      cfg_wr(SEL_CTRL, 32'h5);
      repeat (6) @(negedge clk);
      chk("R6 no request without edge", req_cycles, r0);
      pulse_irq();
      repeat (10) @(negedge clk);
      chk("R7 edge before base dropped", req_cycles, r0);
      cfg_wr(SEL_DEV_BASE, BASE);
      w0 = wr_cnt;
      pulse_irq();
      repeat (12) @(negedge clk);
      chk("R7 serviced after base", wr_cnt - w0, 1);
      chk("R4 first buffer address", wlog_a[w0 % 256], 32'h40);
      chk("R5 device data to buffer", wlog_d[w0 % 256], 32'h5A00_0000);
      pulse_irq();
      repeat (12) @(negedge clk);
      chk("R8 two words", wr_cnt - w0, 2);
      chk("R4 second buffer address", wlog_a[(w0 + 1) % 256], 32'h41);
      chk("R9 done after paced run", {31'd0, done_irq}, 1);

      for (int v = 0; v < NV; v++) run_vec(VECS[v]);

      // line held high moves one word
      cfg_wr(SEL_DEV_OFF, 32'h4);
      cfg_wr(SEL_BUF_PTR, 32'h80);
      cfg_wr(SEL_WORDS, 32'd3);
      w0 = wr_cnt;
      cfg_wr(SEL_CTRL, 32'hD);
      @(negedge clk);
      dev_irq = 1'b1;
      repeat (25) @(negedge clk);
      chk("R6 held line one word", wr_cnt - w0, 1);
      dev_irq = 1'b0;
      repeat (3) @(negedge clk);
      pulse_irq();
      repeat (12) @(negedge clk);
      pulse_irq();
      repeat (12) @(negedge clk);
      chk("R6 three edges three words", wr_cnt - w0, 3);
      chk("R9 done after held run", {31'd0, done_irq}, 1);

      // zero count
      cfg_wr(SEL_WORDS, 32'd0);
      r0 = req_cycles;
      w0 = wr_cnt;
      cfg_wr(SEL_CTRL, 32'h9);
      chk("R9 done cleared by ack", {31'd0, done_irq}, 0);
      @(negedge clk);
      chk("R8 zero count completes", {31'd0, done_irq}, 1);
      repeat (5) @(negedge clk);
      chk("R8 zero count no access", req_cycles, r0);

      // done persists until acknowledged
      repeat (10) @(negedge clk);
      chk("R9 done persists", {31'd0, done_irq}, 1);
      cfg_wr(SEL_CTRL, 32'h8);
      chk("R9 done acknowledged", {31'd0, done_irq}, 0);

      // start and direction change during a running transfer are ignored
      cfg_wr(SEL_WORDS, 32'd2);
      cfg_wr(SEL_BUF_PTR, 32'hA0);
      w0 = wr_cnt;
      cfg_wr(SEL_CTRL, 32'h5);
      repeat (3) @(negedge clk);
      cfg_wr(SEL_CTRL, 32'h3);
      pulse_irq();
      repeat (12) @(negedge clk);
      pulse_irq();
      repeat (12) @(negedge clk);
      chk("R2 busy write ignored count", wr_cnt - w0, 2);
      chk("R2 direction kept", wlog_a[w0 % 256], 32'hA0);
      chk("R9 done after busy test", {31'd0, done_irq}, 1);
      r0 = req_cycles;
      pulse_irq();
      repeat (12) @(negedge clk);
      pulse_irq();
      repeat (12) @(negedge clk);
      chk("R2 go bit self cleared", req_cycles, r0);
      chk("R8 no words after end", wr_cnt - w0, 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule